// File: doc/BRIEF.md
# Double-width split-word FIR filter

This block computes one high-precision 8-tap convolution from two narrow 12-by-12 filter halves. Either the sample or the coefficient is 24 bits wide, and the other operand stays at 12 bits. The wide operand is split in two. The upper half goes through the first filter bank and the lower half through the second. Both banks step through the same tap positions, so each upper-half coefficient or sample meets its matching lower half. The lower bank's full-precision sum is shifted right arithmetically by twelve bits and then added to the upper bank's sum. A programmable window of the combined sum is rounded and clipped to a signed 16-bit output.

A 4-bit mode register selects the variant.
- Writing 0x8 splits the data. The primary input carries sample bits 23:12 and the secondary input carries bits 11:0. Both coefficient banks are loaded with the same 12-bit coefficient set.
- Writing 0xC splits the coefficients. The first bank holds coefficient bits 23:12, the second holds bits 11:0, and both banks filter the primary input.
- Any other value switches the combining off.

A clock enable freezes the whole data pipeline.

Top module: `wide_split_fir`

## Requirements
- R1: The 4-bit mode register resets to 0 and is loaded from `cfg_wdata` on any clock edge where `cfg_we` is 1, whatever the state of `ce`. Its fields are: bit 3 enables combining, bit 2 selects coefficient splitting (1) or data splitting (0), bit 1 selects dual-filter operation and bit 0 selects cascading. Only 0x8 and 0xC are legal.
- R2: With mode 0x8, the wide sample is x = signed(`din_hi`)·4096 + unsigned(`din_lo`). Both banks must hold the same signed 12-bit coefficients c[k]. The exact convolution is y[n] = Σ c[k]·x[n−k].
- R3: With mode 0xC, the wide coefficient is c[k] = signed(bank-A word)·4096 + unsigned(bank-B word). The sample is signed(`din_hi`), and `din_lo` has no effect on the output.
- R4: The combined sum S equals A + (B >>> 12), where A and B are the exact bank sums. This equals floor(y/4096) of the 24-bit convolution.
- R5: A write through port A (or B) with address k stores the coefficient of tap k of that bank. Tap k multiplies the sample accepted k enable-cycles earlier. There are 8 taps.
- R6: With `out_pos` = p, the output is (S + 2^(p−1)) >>> p for p > 0 and S for p = 0. The result is clipped to the range −32768..32767.
- R7: A sample accepted at a clock edge with `ce` high affects `dout` after the second following edge with `ce` high. `dout_vld` follows the mode register with the same two-edge lag.
- R8: While `ce` is 0, the tap lines, the accumulators, `dout` and `dout_vld` all hold their values.
- R9: While the mode register holds an illegal value, `dout_vld` is 0 and `dout` is 0 once the pipeline has advanced two enabled edges.
- R10: After reset, `dout` is 0, `dout_vld` is 0, and all taps and coefficients are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Pipeline clock enable |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 4 | Mode register write value |
| din_hi | input | 12 | Primary sample input (upper half or full narrow sample) |
| din_lo | input | 12 | Secondary sample input (lower half of a wide sample) |
| ca_we | input | 1 | Bank A coefficient write strobe |
| ca_addr | input | 3 | Bank A tap index |
| ca_data | input | 12 | Bank A coefficient word |
| cb_we | input | 1 | Bank B coefficient write strobe |
| cb_addr | input | 3 | Bank B tap index |
| cb_data | input | 12 | Bank B coefficient word |
| out_pos | input | 5 | Bit position of the output window in the combined sum |
| dout | output | 16 | Rounded, saturated combined result |
| dout_vld | output | 1 | Result valid (legal wide mode) |

## Verification
On every cycle the assertions check three things:
- A disabled `ce` freezes the tap lines, both accumulators and the output register.
- A pipeline stage that carries an illegal mode never raises `dout_vld`.
- An invalid output is always zero.

The arithmetic can only be shown by the bench's sweeps, which compare each output with a 64-bit model of the exact 24-bit convolution. This covers the recombination with the floor shift, the signed and unsigned handling of each half, tap ordering, rounding at every window position, saturation at both rails, the two-edge latency, and that `din_lo` is ignored when the coefficients are split.

// File: rtl/wsf_pkg.sv
package wsf_pkg;

   typedef struct packed {
      logic combine;     // bit 3
      logic split_coef;  // bit 2
      logic dual;        // bit 1
      logic cascade;     // bit 0
   } wsf_mode_t;

   function automatic logic mode_legal(wsf_mode_t m);
      return m.combine && !m.dual && !m.cascade;
   endfunction

endpackage

// File: rtl/wsf_tapline.sv
module wsf_tapline #(
   parameter int W    = 12,
   parameter int TAPS = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ce,
   input  logic [W-1:0]              din,
   output logic [TAPS-1:0][W-1:0]    taps
);

   generate
      for (genvar i = 0; i < TAPS; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n)  taps[0] <= '0;
               else if (ce) taps[0] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n)  taps[i] <= '0;
               else if (ce) taps[i] <= taps[i-1];
            end
         end
      end
   endgenerate

   // R8
   tap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(taps));

endmodule

// File: rtl/wsf_bank.sv
module wsf_bank #(
   parameter int DW   = 12,
   parameter int TAPS = 8,
   localparam int AW   = $clog2(TAPS),
   localparam int PW   = 2 * (DW + 1),
   localparam int ACCW = PW + $clog2(TAPS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ce,
   input  logic                      coef_we,
   input  logic [AW-1:0]             coef_addr,
   input  logic [DW-1:0]             coef_data,
   input  logic [TAPS-1:0][DW-1:0]   taps,
   input  logic                      data_uns,
   input  logic                      coef_uns,
   output logic signed [ACCW-1:0]    acc
);

   logic [TAPS-1:0][DW-1:0] coef_q;
   logic signed [PW-1:0]    prod [TAPS];
   logic signed [ACCW-1:0]  sum_c;

   always_ff @(posedge clk) begin
      if (!rst_n) coef_q <= '0;
      else if (coef_we && (int'(coef_addr) < TAPS)) coef_q[coef_addr] <= coef_data;
   end

   generate
      for (genvar k = 0; k < TAPS; k++) begin : g_tap
         logic signed [DW:0] d_ext, c_ext;
         assign d_ext = data_uns ? {1'b0, taps[k]}   : {taps[k][DW-1], taps[k]};
         assign c_ext = coef_uns ? {1'b0, coef_q[k]} : {coef_q[k][DW-1], coef_q[k]};
         assign prod[k] = d_ext * c_ext;
      end
   endgenerate

   always_comb begin
      sum_c = '0;
      for (int k = 0; k < TAPS; k++)
         sum_c = sum_c + {{(ACCW-PW){prod[k][PW-1]}}, prod[k]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  acc <= '0;
      else if (ce) acc <= sum_c;
   end

   // R8
   acc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(acc));

endmodule

// File: rtl/wsf_combine.sv
module wsf_combine #(
   parameter int ACCW = 29,
   parameter int OUTW = 16,
   parameter int LOSH = 12,
   localparam int SW  = ACCW + 3,
   localparam int PSW = $clog2(SW)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ce,
   input  logic signed [ACCW-1:0]  acc_hi,
   input  logic signed [ACCW-1:0]  acc_lo,
   input  logic [PSW-1:0]          pos,
   input  logic                    legal_in,
   output logic [OUTW-1:0]         dout,
   output logic                    dout_vld
);

   localparam logic signed [SW-1:0] MAXV = {{(SW-OUTW+1){1'b0}}, {(OUTW-1){1'b1}}};
   localparam logic signed [SW-1:0] MINV = {{(SW-OUTW+1){1'b1}}, {(OUTW-1){1'b0}}};

   logic signed [ACCW-1:0] lo_shr;
   logic signed [SW-1:0]   s_sum, s_half, s_rnd, s_shf;
   logic [OUTW-1:0]        sat_c;

   always_comb begin
      lo_shr = acc_lo >>> LOSH;
      s_sum  = {{3{acc_hi[ACCW-1]}}, acc_hi} + {{3{lo_shr[ACCW-1]}}, lo_shr};
      s_half = (pos == '0) ? '0 : (SW'(1) << (pos - 1'b1));
      s_rnd  = s_sum + s_half;
      s_shf  = s_rnd >>> pos;
      if (s_shf > MAXV)      sat_c = MAXV[OUTW-1:0];
      else if (s_shf < MINV) sat_c = MINV[OUTW-1:0];
      else                   sat_c = s_shf[OUTW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout     <= '0;
         dout_vld <= 1'b0;
      end else if (ce) begin
         dout_vld <= legal_in;
         dout     <= legal_in ? sat_c : '0;
      end
   end

   // R9
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_vld |-> dout == '0);

endmodule

// File: rtl/wide_split_fir.sv
module wide_split_fir #(
   parameter int DW   = 12,
   parameter int TAPS = 8,
   parameter int OUTW = 16,
   localparam int AW   = $clog2(TAPS),
   localparam int ACCW = 2 * (DW + 1) + $clog2(TAPS),
   localparam int SW   = ACCW + 3,
   localparam int PSW  = $clog2(SW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             cfg_we,
   input  logic [3:0]       cfg_wdata,
   input  logic [DW-1:0]    din_hi,
   input  logic [DW-1:0]    din_lo,
   input  logic             ca_we,
   input  logic [AW-1:0]    ca_addr,
   input  logic [DW-1:0]    ca_data,
   input  logic             cb_we,
   input  logic [AW-1:0]    cb_addr,
   input  logic [DW-1:0]    cb_data,
   input  logic [PSW-1:0]   out_pos,
   output logic [OUTW-1:0]  dout,
   output logic             dout_vld
);
   import wsf_pkg::*;

   generate
      if (TAPS < 2) begin : g_bad_taps
         $error("wide_split_fir: TAPS must be at least 2");
      end
      if (DW < 2) begin : g_bad_dw
         $error("wide_split_fir: DW must be at least 2");
      end
      if (OUTW < 2 || OUTW > SW) begin : g_bad_outw
         $error("wide_split_fir: OUTW out of range");
      end
   endgenerate

   wsf_mode_t mode_q;
   logic      legal_now, legal_d1;
   logic [DW-1:0] lo_line_in;
   logic [TAPS-1:0][DW-1:0] taps_hi, taps_lo;
   logic signed [ACCW-1:0] acc_hi, acc_lo;

   always_ff @(posedge clk) begin
      if (!rst_n)      mode_q <= '0;
      else if (cfg_we) mode_q <= wsf_mode_t'(cfg_wdata);
   end

   assign legal_now  = mode_legal(mode_q);
   assign lo_line_in = mode_q.split_coef ? din_hi : din_lo;

   always_ff @(posedge clk) begin
      if (!rst_n)  legal_d1 <= 1'b0;
      else if (ce) legal_d1 <= legal_now;
   end

   wsf_tapline #(.W(DW), .TAPS(TAPS)) i_line_hi (
      .clk(clk), .rst_n(rst_n), .ce(ce), .din(din_hi), .taps(taps_hi));

   wsf_tapline #(.W(DW), .TAPS(TAPS)) i_line_lo (
      .clk(clk), .rst_n(rst_n), .ce(ce), .din(lo_line_in), .taps(taps_lo));

   wsf_bank #(.DW(DW), .TAPS(TAPS)) i_bank_hi (
      .clk(clk), .rst_n(rst_n), .ce(ce),
      .coef_we(ca_we), .coef_addr(ca_addr), .coef_data(ca_data),
      .taps(taps_hi), .data_uns(1'b0), .coef_uns(1'b0), .acc(acc_hi));

   wsf_bank #(.DW(DW), .TAPS(TAPS)) i_bank_lo (
      .clk(clk), .rst_n(rst_n), .ce(ce),
      .coef_we(cb_we), .coef_addr(cb_addr), .coef_data(cb_data),
      .taps(taps_lo), .data_uns(!mode_q.split_coef), .coef_uns(mode_q.split_coef),
      .acc(acc_lo));

   wsf_combine #(.ACCW(ACCW), .OUTW(OUTW), .LOSH(DW)) i_combine (
      .clk(clk), .rst_n(rst_n), .ce(ce),
      .acc_hi(acc_hi), .acc_lo(acc_lo), .pos(out_pos), .legal_in(legal_d1),
      .dout(dout), .dout_vld(dout_vld));

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(dout) && $stable(dout_vld));

   // R9
   illegal_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce && !legal_d1 |=> !dout_vld);

endmodule

// File: tb/test_wide_split_fir.sv
module test_wide_split_fir;
   localparam int DW = 12, TAPS = 8, OUTW = 16, AW = 3, PSW = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, ce, cfg_we, ca_we, cb_we, dout_vld;
   logic [3:0] cfg_wdata;
   logic [DW-1:0] din_hi, din_lo, ca_data, cb_data;
   logic [AW-1:0] ca_addr, cb_addr;
   logic [PSW-1:0] out_pos;
   logic [OUTW-1:0] dout;

   wide_split_fir i_wide_split_fir (
      .clk(clk), .rst_n(rst_n), .ce(ce), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .din_hi(din_hi), .din_lo(din_lo),
      .ca_we(ca_we), .ca_addr(ca_addr), .ca_data(ca_data),
      .cb_we(cb_we), .cb_addr(cb_addr), .cb_data(cb_data),
      .out_pos(out_pos), .dout(dout), .dout_vld(dout_vld));

   int checks = 0, errors = 0;
   longint hist [TAPS];
   longint cw [TAPS];
   longint expv [0:1023];

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint sx12(logic [11:0] v);
      return longint'($signed(v));
   endfunction

   function automatic longint out_model(longint s, int p);
      longint r;
      r = (p > 0) ? ((s + (64'sd1 <<< (p - 1))) >>> p) : s;
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   task automatic set_cfg(logic [3:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_coefs(int mode, int kind);
      for (int k = 0; k < TAPS; k++) begin
         logic [11:0] ch, cl;
         ch = 12'($urandom); cl = 12'($urandom);
         if (kind == 1) begin ch = 12'h7FF; cl = 12'hFFF; end
         if (kind == 2) begin ch = 12'h7FF; cl = 12'h000; end
         ca_we = 1'b1; ca_addr = AW'(k); ca_data = ch;
         cb_we = 1'b1; cb_addr = AW'(k); cb_data = (mode == 1) ? cl : ch;
         cw[k] = (mode == 1) ? sx12(ch) * 4096 + longint'(cl) : sx12(ch);
         @(negedge clk);
      end
      ca_we = 1'b0; cb_we = 1'b0;
   endtask

   task automatic run(int mode, int pos, int kind, int nsamp, bit do_stall);
      string tag;
      tag = (mode == 1) ? "R3/R4/R6" : "R2/R4/R5/R6/R7";
      ce = 1'b0;
      out_pos = PSW'(pos);
      set_cfg((mode == 1) ? 4'hC : 4'h8);
      load_coefs(mode, kind);
      for (int k = 0; k < TAPS; k++) hist[k] = 0;
      ce = 1'b1;
      for (int n = 0; n < nsamp; n++) begin
         logic [11:0] hi, lo;
         longint y;
         if (n >= 3 && n - 3 >= TAPS - 1) begin
            chk($signed(dout) == expv[n-3], tag, longint'($signed(dout)), expv[n-3]);
            chk(dout_vld == 1'b1, "R1 valid", longint'(dout_vld), 1);
         end
         if (do_stall && n == nsamp / 2) begin
            logic [OUTW-1:0] held;
            logic held_v;
            held = dout; held_v = dout_vld;
            ce = 1'b0;
            for (int s = 0; s < 4; s++) begin
               din_hi = 12'($urandom); din_lo = 12'($urandom);
               @(negedge clk);
               chk(dout == held && dout_vld == held_v, "R8 stall hold",
                   longint'($signed(dout)), longint'($signed(held)));
            end
            ce = 1'b1;
         end
         hi = 12'($urandom); lo = 12'($urandom);
         if (kind == 1) begin hi = 12'h7FF; lo = 12'hFFF; end
         if (kind == 2) begin hi = 12'h800; lo = 12'h000; end
         din_hi = hi; din_lo = lo;
         for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
         hist[0] = (mode == 1) ? sx12(hi) : sx12(hi) * 4096 + longint'(lo);
         y = 0;
         for (int k = 0; k < TAPS; k++) y += cw[k] * hist[k];
         expv[n] = out_model(y >>> 12, pos);
         @(negedge clk);
      end
   endtask

   initial begin
      #(20 * 150000);
      checks++; errors++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ce = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
      din_hi = '0; din_lo = '0; ca_we = 1'b0; cb_we = 1'b0;
      ca_addr = '0; cb_addr = '0; ca_data = '0; cb_data = '0; out_pos = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dout == '0, "R10 reset dout", longint'(dout), 0);
      chk(dout_vld == 1'b0, "R10 reset valid", longint'(dout_vld), 0);

      // reset state: all-zero coefficients give zero even in a legal mode
      set_cfg(4'h8);
      ce = 1'b1;
      din_hi = 12'h7FF; din_lo = 12'hFFF;
      repeat (4) @(negedge clk);
      chk(dout == '0, "R10 zero coefficients", longint'($signed(dout)), 0);

      // illegal mode values
      foreach (cfg_wdata[i]) begin end
      for (int v = 0; v < 16; v++) begin
         if (v == 8 || v == 12) continue;
         set_cfg(4'(v));
         repeat (3) @(negedge clk);
         chk(dout_vld == 1'b0, "R9 illegal valid", longint'(dout_vld), 0);
         chk(dout == '0, "R9 illegal dout", longint'(dout), 0);
      end

      // R1 write while disabled, R7 valid lag of two enabled edges
      ce = 1'b0;
      set_cfg(4'h8);
      chk(dout_vld == 1'b0, "R1 frozen valid", longint'(dout_vld), 0);
      ce = 1'b1;
      @(negedge clk);
      chk(dout_vld == 1'b0, "R7 valid lag", longint'(dout_vld), 0);
      @(negedge clk);
      chk(dout_vld == 1'b1, "R1 legal valid", longint'(dout_vld), 1);

      run(0, 12, 0, 120, 1'b1);
      run(1, 12, 0, 120, 1'b1);
      run(0, 4, 0, 60, 1'b0);
      run(1, 0, 0, 60, 1'b0);
      run(0, 16, 0, 60, 1'b0);
      run(0, 0, 1, 30, 1'b0);
      run(0, 0, 2, 30, 1'b0);
      run(1, 8, 1, 30, 1'b0);
      run(1, 20, 2, 30, 1'b0);
      for (int p = 0; p < 31; p++) run(p % 2, p, 0, 20, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule